// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel samples. It watches three serial inputs: a bit clock, a channel-select (word) clock and a data line. All three are brought into the system clock domain through a synchronizer. Each data bit is taken at a rising edge of the bit clock, and the block works out from the word clock where each channel's field begins and ends.

Three framings are supported. In right-justified framing the word ends on the last bit before the next word-clock change. Its length is 16, 20 or 24 bits. In I2S framing the MSB comes one bit after the word-clock change, and a low word clock marks the left channel. In left-justified framing the MSB sits on the first bit of the field. A strap input forces left-justified framing whatever the format code says.

Each completed word is placed MSB-first in a 24-bit two's-complement output, with its low bits filled with zero. A one-cycle valid strobe marks it on that channel's output. The strobe fires when the next field starts, because that is when the block learns the field is over.

Top module: `serial_audio_rx`

## Requirements
- R1: Data is taken at each rising edge of the bit clock, MSB first, in two's complement. Every output word is MSB-aligned in 24 bits, and any bit below the received word is zero.
- R2: `fmt_i` selects the framing when the strap is low: 2'b00 right-justified 16-bit, 2'b01 I2S, 2'b10 right-justified 20-bit, 2'b11 right-justified 24-bit.
- R3: Right-justified framing uses the word clock high for left. The word is the last N bits before the next word-clock change. Bits earlier in the field have no effect on the output.
- R4: I2S framing uses the word clock low for left. The first bit of a field, taken at the edge where the word clock changed, is ignored. The MSB is the second bit.
- R5: When `lj_strap_i` is high, left-justified framing is used whatever the value of `fmt_i`. The word clock is high for left, and the MSB is the first bit of the field.
- R6: In I2S and left-justified framing, at most 24 word bits are kept and later bits are ignored. A field that ends sooner leaves the remaining low bits zero, so 16-, 18-, 20- and 24-bit words are all accepted.
- R7: Right-justified 16-bit framing also works with 16 bit clocks per channel, where the MSB sits on one word-clock change and the LSB sits just before the next one.
- R8: A finished field is presented on its channel's output with a valid strobe exactly one system cycle long. The left and right strobes never fire in the same cycle. Within a frame, the left field comes before the right field.
- R9: Reset clears both outputs to zero and both strobes low. The first field seen after reset is incomplete and is never presented.
- R10: The serial inputs pass through a two-stage synchronizer. The valid strobe for a field goes high on the third system clock edge after the bit-clock rise at which the next field begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| lrclk_i | input | 1 | Channel-select word clock, asynchronous |
| sdata_i | input | 1 | Serial data |
| fmt_i | input | 2 | Framing and word-length code |
| lj_strap_i | input | 1 | Forces left-justified framing |
| left_o | output | 24 | Left sample, MSB-aligned |
| left_vld_o | output | 1 | One-cycle strobe for a new left sample |
| right_o | output | 24 | Right sample, MSB-aligned |
| right_vld_o | output | 1 | One-cycle strobe for a new right sample |

## Verification
Corrupted internal state shows up at the outputs at the next field boundary, and no later. A bit counter off by one shifts every left-justified or I2S word by one bit in the very next sample. A wrong channel-polarity decode swaps the left and right results within one frame. A wrong arming flag, or a stale previous word-clock value, shows as an extra strobe or a missing strobe right after reset. Every test stimulus fills the ignored bit slots with ones, so a capture window that sits in the wrong place flips visible output bits straight away.

// File: rtl/asrx_pkg.sv
package asrx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int RJ_SHORT = 16;
  localparam int RJ_MID   = 20;
  localparam int RJ_LONG  = 24;

  typedef enum logic [1:0] {
    FMT_RJ16 = 2'b00,
    FMT_I2S  = 2'b01,
    FMT_RJ20 = 2'b10,
    FMT_RJ24 = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    FR_RJ  = 2'd0,
    FR_I2S = 2'd1,
    FR_LJ  = 2'd2
  } framing_e;
endpackage

// File: rtl/asrx_sync.sv
module asrx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/asrx_framer.sv
module asrx_framer
  import asrx_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk_s,
  input  logic             ws_s,
  input  logic [1:0]       fmt_i,
  input  logic             lj_i,
  output logic             stb_o,
  output logic             start_o,
  output logic             emit_o,
  output logic             end_left_o,
  output logic [IDX_W-1:0] idx_o,
  output framing_e         framing_o
);
  logic             bclk_d;
  logic             ws_prev;
  logic             seen;
  logic             armed;
  logic [IDX_W-1:0] cnt;
  logic             left_lvl;

  always_comb begin
    if (lj_i)                        framing_o = FR_LJ;
    else if (fmt_e'(fmt_i) == FMT_I2S) framing_o = FR_I2S;
    else                             framing_o = FR_RJ;
  end

  assign left_lvl   = (framing_o != FR_I2S);
  assign stb_o      = bclk_s & ~bclk_d;
  assign start_o    = stb_o & seen & (ws_s != ws_prev);
  assign emit_o     = start_o & armed;
  assign end_left_o = (ws_prev == left_lvl);
  assign idx_o      = start_o ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_d  <= 1'b0;
      ws_prev <= 1'b0;
      seen    <= 1'b0;
      armed   <= 1'b0;
      cnt     <= '0;
    end else begin
      bclk_d <= bclk_s;
      if (stb_o) begin
        seen    <= 1'b1;
        ws_prev <= ws_s;
        if (start_o) armed <= 1'b1;
        if (idx_o != '1) cnt <= idx_o + 1'b1;
      end
    end
  end

  // R10
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    stb_o |=> !stb_o);

  // R9
  emit_armed_chk: assert property (@(posedge clk) disable iff (rst)
    emit_o |-> seen);
endmodule

// File: rtl/asrx_capture.sv
module asrx_capture
  import asrx_pkg::*;
#(
  parameter int OUT_W = 24,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb_i,
  input  logic             bit_i,
  input  logic             start_i,
  input  logic [IDX_W-1:0] idx_i,
  input  framing_e         framing_i,
  input  logic [1:0]       fmt_i,
  output logic [OUT_W-1:0] word_o
);
  logic [OUT_W-1:0] sh;
  logic [OUT_W-1:0] acc;
  logic [OUT_W-1:0] acc_nx;
  int               pos;
  int               shamt;

  always_comb begin
    acc_nx = start_i ? '0 : acc;
    pos    = int'(idx_i) - ((framing_i == FR_I2S) ? 1 : 0);
    if (pos >= 0 && pos < OUT_W) acc_nx[OUT_W-1-pos] = bit_i;
  end

  always_comb begin
    unique case (fmt_e'(fmt_i))
      FMT_RJ16: shamt = OUT_W - RJ_SHORT;
      FMT_RJ20: shamt = OUT_W - RJ_MID;
      default:  shamt = OUT_W - RJ_LONG;
    endcase
    word_o = (framing_i == FR_RJ) ? (sh << shamt) : acc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      acc <= '0;
    end else if (stb_i) begin
      sh  <= {sh[OUT_W-2:0], bit_i};
      acc <= acc_nx;
    end
  end

  // R6
  acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stb_i && start_i && framing_i == FR_LJ) |=> (acc[OUT_W-2:0] == '0));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import asrx_pkg::*;
#(
  parameter int OUT_W       = SAMPLE_W,
  parameter int SYNC_STAGES = 2,
  parameter int MAX_FIELD   = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk_i,
  input  logic             lrclk_i,
  input  logic             sdata_i,
  input  logic [1:0]       fmt_i,
  input  logic             lj_strap_i,
  output logic [OUT_W-1:0] left_o,
  output logic             left_vld_o,
  output logic [OUT_W-1:0] right_o,
  output logic             right_vld_o
);
  localparam int IDX_W = $clog2(MAX_FIELD) + 1;

  logic [2:0]       sync_q;
  logic             stb, start, emit, end_left;
  logic [IDX_W-1:0] idx;
  framing_e         framing;
  logic [OUT_W-1:0] word;

  asrx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({bclk_i, lrclk_i, sdata_i}),
    .q_o (sync_q)
  );

  asrx_framer #(.IDX_W(IDX_W)) u_framer (
    .clk        (clk),
    .rst        (rst),
    .bclk_s     (sync_q[2]),
    .ws_s       (sync_q[1]),
    .fmt_i      (fmt_i),
    .lj_i       (lj_strap_i),
    .stb_o      (stb),
    .start_o    (start),
    .emit_o     (emit),
    .end_left_o (end_left),
    .idx_o      (idx),
    .framing_o  (framing)
  );

  asrx_capture #(.OUT_W(OUT_W), .IDX_W(IDX_W)) u_capture (
    .clk       (clk),
    .rst       (rst),
    .stb_i     (stb),
    .bit_i     (sync_q[0]),
    .start_i   (start),
    .idx_i     (idx),
    .framing_i (framing),
    .fmt_i     (fmt_i),
    .word_o    (word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      left_o      <= '0;
      right_o     <= '0;
      left_vld_o  <= 1'b0;
      right_vld_o <= 1'b0;
    end else begin
      left_vld_o  <= 1'b0;
      right_vld_o <= 1'b0;
      if (emit) begin
        if (end_left) begin
          left_o     <= word;
          left_vld_o <= 1'b1;
        end else begin
          right_o     <= word;
          right_vld_o <= 1'b1;
        end
      end
    end
  end

  // R8
  left_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    left_vld_o |=> !left_vld_o);

  // R8
  right_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    right_vld_o |=> !right_vld_o);

  // R8
  excl_vld_chk: assert property (@(posedge clk) disable iff (rst)
    !(left_vld_o && right_vld_o));

  // R10
  vld_after_stb_chk: assert property (@(posedge clk) disable iff (rst)
    (left_vld_o || right_vld_o) |-> $past(stb));

  // R9
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (left_o == '0 && right_o == '0 && !left_vld_o && !right_vld_o));
endmodule

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk = 1'b0, ws = 1'b0, sd = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic        strap = 1'b0;
  logic [23:0] left_o, right_o;
  logic        left_vld_o, right_vld_o;

  int errors = 0, checks = 0;
  int since = 0, lat = 0;
  int left_cnt = 0, right_cnt = 0, strobe_err = 0;
  logic [23:0] left_cap = '0, right_cap = '0;
  logic prev_l = 1'b0, prev_r = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_audio_rx i_serial_audio_rx (
    .clk(clk), .rst(rst), .bclk_i(bclk), .lrclk_i(ws), .sdata_i(sd),
    .fmt_i(fmt), .lj_strap_i(strap),
    .left_o(left_o), .left_vld_o(left_vld_o),
    .right_o(right_o), .right_vld_o(right_vld_o)
  );

  // {fmt[2], strap, half[6], wlen[5], left[24], right[24]}
  localparam logic [61:0] VEC [NVEC] = '{
    {2'b00, 1'b0, 6'd32, 5'd16, 24'h008001, 24'h007FFE},  // R2 R3 RJ16
    {2'b10, 1'b0, 6'd32, 5'd20, 24'h0ABCDE, 24'h012345},  // R2 R3 RJ20
    {2'b11, 1'b0, 6'd32, 5'd24, 24'hC0FFEE, 24'h123456},  // R2 R3 RJ24
    {2'b01, 1'b0, 6'd32, 5'd24, 24'h9A5B3C, 24'h0F1E2D},  // R2 R4 I2S 24
    {2'b01, 1'b0, 6'd32, 5'd16, 24'h00BEEF, 24'h000001},  // R4 R6 I2S 16
    {2'b00, 1'b1, 6'd32, 5'd24, 24'h876543, 24'h00FF01},  // R5 LJ 24
    {2'b11, 1'b1, 6'd32, 5'd18, 24'h02ABCD, 24'h01FFFF},  // R5 R6 LJ 18
    {2'b00, 1'b0, 6'd16, 5'd16, 24'h00A55A, 24'h005AA5},  // R7 packed
    {2'b01, 1'b1, 6'd16, 5'd16, 24'h001234, 24'h00FEDC}   // R5 R6 short LJ
  };

  always @(posedge clk) since = since + 1;

  always @(negedge clk) begin
    #1;
    if (left_vld_o) begin
      left_cap = left_o; left_cnt++; lat = since;
      if (prev_l || right_vld_o) strobe_err++;
    end
    if (right_vld_o) begin
      right_cap = right_o; right_cnt++;
      if (prev_r) strobe_err++;
    end
    prev_l = left_vld_o; prev_r = right_vld_o;
  end

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic w, input logic d);
    @(negedge clk); bclk = 1'b0; ws = w; sd = d;
    @(negedge clk);
    @(negedge clk); bclk = 1'b1; since = 0;
    @(negedge clk);
  endtask

  // kind: 0 right-justified, 1 I2S, 2 left-justified
  function automatic logic gen(input int kind, input int half, input int wlen,
                               input logic [23:0] w, input int i);
    int p;
    if (kind == 0) return (i >= half - wlen) ? w[half-1-i] : 1'b1;
    p = (kind == 1) ? i - 1 : i;
    if (p < 0) return 1'b1;
    if (p < wlen) return w[wlen-1-p];
    return (p >= 24) ? 1'b1 : 1'b0;
  endfunction

  task automatic send_half(input int kind, input logic lvl, input int half,
                           input int wlen, input logic [23:0] w, input logic dummy);
    for (int i = 0; i < half; i++)
      send_bit(lvl, dummy ? 1'b0 : gen(kind, half, wlen, w, i));
  endtask

  function automatic logic [23:0] expect_of(input logic [23:0] w, input int wlen);
    return w << (24 - wlen);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #2;
    // R9 reset state
    check("R9 reset left", left_o, 24'h0);
    check("R9 reset right", right_o, 24'h0);
    check("R9 reset strobes", {22'h0, left_vld_o, right_vld_o}, 24'h0);

    // R9 partial first field never presented
    for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b1);
    for (int i = 0; i < 8; i++) send_bit(1'b0, 1'b1);
    repeat (4) @(negedge clk);
    check("R9 no strobe for partial field", 24'(left_cnt + right_cnt), 24'h0);

    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] vf; logic vs; int half, wlen, kind; logic [23:0] lw, rw; logic lvl;
      {vf, vs} = VEC[v][61:59];
      half = int'(VEC[v][58:53]);
      wlen = int'(VEC[v][52:48]);
      lw = VEC[v][47:24]; rw = VEC[v][23:0];
      fmt = vf; strap = vs;
      kind = vs ? 2 : ((vf == 2'b01) ? 1 : 0);
      lvl = (kind != 1);
      send_half(kind, ~lvl, half, wlen, 24'h0, 1'b1);
      send_half(kind, lvl, half, wlen, lw, 1'b0);
      send_half(kind, ~lvl, half, wlen, rw, 1'b0);
      if (v == 0) check("R10 strobe latency", 24'(lat), 24'd3);
      send_half(kind, lvl, half, wlen, 24'h0, 1'b1);
      repeat (4) @(negedge clk);
      // R1 R2 R3 R4 R5 R6 R7: MSB-aligned words
      check($sformatf("R1 vector %0d left", v), left_cap, expect_of(lw, wlen));
      check($sformatf("R1 vector %0d right", v), right_cap, expect_of(rw, wlen));
    end

    // R8 one-cycle strobes, never together
    check("R8 strobe shape", 24'(strobe_err), 24'h0);
    check("R8 strobe counts seen", 24'(left_cnt >= NVEC && right_cnt >= NVEC), 24'h1);

    // R9 reset in mid-stream clears outputs
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk); #2;
    check("R9 mid reset left", left_o, 24'h0);
    check("R9 mid reset right", right_o, 24'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule